// File: doc/BRIEF.md
# Adaptive Fill Insertion Controller

This block chooses where a line that has just been filled after a miss enters the recency stack of one set of a set-associative cache. It has two insertion behaviours. The conventional one always places the new line at the most-recently-used end. The bimodal one places it at the least-recently-used end, so that a line which is never referenced again is the next victim. About one fill in 32 is still placed at the most-recently-used end, so the cache can follow a change in working set.

Two small groups of sets are reserved. Each group always uses one of the two behaviours. Every fill in a reserved set counts as a miss for that set's behaviour and moves a shared saturating selector. All the other sets, called followers, use whichever behaviour the selector currently favours. The cache presents one fill event per cycle with its set index. The block answers combinationally in the same cycle with a single bit: insert at the most-recently-used end or at the least-recently-used end. Recency updates on hits, tags and data belong to the surrounding cache.

Top module: `ins_policy_ctl`

## Requirements
- R1: After reset the selector holds 511 (0x1FF), so `bimodal_sel` is 0, and the random source holds 16'hACE1.
- R2: A set whose index bits [9:5] equal bits [4:0] is reserved for conventional insertion. A fill there always drives `insert_mru` to 1, whatever the selector holds.
- R3: A set whose index bits [9:5] equal the bitwise inverse of bits [4:0] is reserved for bimodal insertion. A fill there drives `insert_mru` to 1 exactly when the low 5 bits of the random source are all zero in that cycle.
- R4: A fill in a follower set (any set not covered by R2 or R3) while `bimodal_sel` is 0 drives `insert_mru` to 1.
- R5: A fill in a follower set while `bimodal_sel` is 1 follows the bimodal draw rule of R3.
- R6: At each clock edge the selector goes up by one after a fill in a conventional-reserved set and down by one after a fill in a bimodal-reserved set. It does not change after a follower fill or a cycle without a fill.
- R7: The 10-bit selector saturates. An increment at 1023 leaves it at 1023, and a decrement at 0 leaves it at 0.
- R8: `bimodal_sel` is the most significant bit of the selector (1 when the selector is 512 or more).
- R9: `insert_mru` is 0 in any cycle where `fill_valid` is 0.
- R10: The random source is a 16-bit shift register that advances at every clock edge out of reset. The next value is {s[14:0], s[15]^s[13]^s[12]^s[10]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | A miss fill is being placed this cycle |
| fill_set | input | 10 | Set index of the fill |
| insert_mru | output | 1 | 1: insert at MRU end; 0: insert at LRU end |
| bimodal_sel | output | 1 | Follower sets currently use bimodal insertion |

## Verification
The hardest behaviour to reach is the selector's saturation at both ends. It can only be reached through long runs of fills in one class of reserved set, and the selector's value shows at the ports only through its top bit. The bench drives more than 512 fills in a row into conventional-reserved sets to pin the selector at its top. It then drives more than 1024 fills into bimodal-reserved sets to pin it at zero. A running model of the selector and the random source predicts the follower decision after every fill, so a lost saturation shows up later as a mismatch in `bimodal_sel` or `insert_mru`. Full sweeps over all 1024 set indices, taken with the selector in both halves, cover every reserved and follower pattern.

// File: rtl/ins_policy_ctl.sv
module ins_policy_ctl #(
  parameter int SET_BITS    = 10,
  parameter int SAMPLE_BITS = 5,
  parameter int PSEL_BITS   = 10,
  parameter int THR_BITS    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fill_valid,
  input  logic [SET_BITS-1:0] fill_set,
  output logic                insert_mru,
  output logic                bimodal_sel
);
  localparam logic [15:0]          RNG_SEED  = 16'hACE1;
  localparam logic [PSEL_BITS-1:0] PSEL_MAX  = '1;
  localparam logic [PSEL_BITS-1:0] PSEL_INIT = {1'b0, {(PSEL_BITS-1){1'b1}}};

  logic [PSEL_BITS-1:0]   psel;
  logic [15:0]            rng;
  logic [SAMPLE_BITS-1:0] idx_hi, idx_lo;
  logic                   lead_conv, lead_bim, draw_mru, use_bim;

  assign idx_hi    = fill_set[SET_BITS-1 -: SAMPLE_BITS];
  assign idx_lo    = fill_set[SAMPLE_BITS-1:0];
  assign lead_conv = (idx_hi == idx_lo);
  assign lead_bim  = (idx_hi == ~idx_lo);
  assign draw_mru  = (rng[THR_BITS-1:0] == '0);
  assign use_bim   = lead_bim | (~lead_conv & bimodal_sel);

  assign bimodal_sel = psel[PSEL_BITS-1];
  assign insert_mru  = fill_valid & (use_bim ? draw_mru : 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rng <= RNG_SEED;
    end else begin
      rng <= {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psel <= PSEL_INIT;
    end else if (fill_valid && lead_conv && psel != PSEL_MAX) begin
      psel <= psel + 1'b1;
    end else if (fill_valid && lead_bim && psel != '0) begin
      psel <= psel - 1'b1;
    end
  end
endmodule

// File: rtl/ins_policy_chk.sv
module ins_policy_chk #(
  parameter int SET_BITS    = 10,
  parameter int SAMPLE_BITS = 5,
  parameter int PSEL_BITS   = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fill_valid,
  input logic [SET_BITS-1:0]  fill_set,
  input logic                 insert_mru,
  input logic                 bimodal_sel,
  input logic [PSEL_BITS-1:0] psel,
  input logic [15:0]          rng
);
  logic c_conv, c_bim;
  assign c_conv = fill_set[SET_BITS-1 -: SAMPLE_BITS] == fill_set[SAMPLE_BITS-1:0];
  assign c_bim  = fill_set[SET_BITS-1 -: SAMPLE_BITS] == ~fill_set[SAMPLE_BITS-1:0];

  assert_idle_lru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_valid |-> !insert_mru);
  assert_conv_lead_mru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && c_conv) |-> insert_mru);
  assert_follow_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !c_conv && !c_bim && !bimodal_sel) |-> insert_mru);
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_valid || (!c_conv && !c_bim)) |=> $stable(psel));
  assert_sat_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && c_conv && psel == '1) |=> psel == '1);
  assert_sat_bottom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && c_bim && psel == '0) |=> psel == '0);
  assert_rng_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rng != 16'h0);
endmodule

bind ins_policy_ctl ins_policy_chk #(
  .SET_BITS(SET_BITS), .SAMPLE_BITS(SAMPLE_BITS), .PSEL_BITS(PSEL_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_set(fill_set),
  .insert_mru(insert_mru), .bimodal_sel(bimodal_sel), .psel(psel), .rng(rng)
);

// File: tb/ins_policy_ctl_tb.sv
module ins_policy_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fill_valid = 1'b0;
  logic [9:0] fill_set = '0;
  logic       insert_mru, bimodal_sel;

  int n_checks = 0;
  int n_fail = 0;
  int m_psel;
  logic [15:0] m_rng;
  bit done = 0;

  always #10 clk = ~clk;

  ins_policy_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_set(fill_set),
    .insert_mru(insert_mru), .bimodal_sel(bimodal_sel)
  );

  function automatic bit is_conv(input logic [9:0] s);
    return s[9:5] == s[4:0];
  endfunction
  function automatic bit is_bim(input logic [9:0] s);
    return s[9:5] == ~s[4:0];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b (set=%0d psel_model=%0d)",
               req, act, exp, fill_set, m_psel);
    end
  endtask

  task automatic step(input logic v, input logic [9:0] s);
    logic exp_mru;
    bit draw, sel;
    fill_valid = v;
    fill_set   = s;
    #1;
    sel  = (m_psel >= 512);
    draw = (m_rng[4:0] == 5'd0);
    check("R8", bimodal_sel, sel);
    if (!v)                exp_mru = 1'b0;
    else if (is_conv(s))   exp_mru = 1'b1;
    else if (is_bim(s))    exp_mru = draw;
    else if (sel)          exp_mru = draw;
    else                   exp_mru = 1'b1;
    if (!v)              check("R9", insert_mru, exp_mru);
    else if (is_conv(s)) check("R2", insert_mru, exp_mru);
    else if (is_bim(s))  check("R3", insert_mru, exp_mru);
    else if (sel)        check("R5", insert_mru, exp_mru);
    else                 check("R4", insert_mru, exp_mru);
    @(posedge clk);
    if (v && is_conv(s) && m_psel < 1023) m_psel++;
    else if (v && is_bim(s) && m_psel > 0) m_psel--;
    m_rng = {m_rng[14:0], m_rng[15] ^ m_rng[13] ^ m_rng[12] ^ m_rng[10]};
    @(negedge clk);
  endtask

  initial begin
    m_psel = 511;
    m_rng  = 16'hACE1;
    repeat (3) @(negedge clk);
    #1;
    check("R1", bimodal_sel, 1'b0);
    rst_n = 1'b1;
    #1;
    for (int i = 0; i < 1024; i++) step(1'b1, 10'(i));
    for (int i = 0; i < 40; i++) step(1'b0, 10'(i * 37));
    for (int i = 0; i < 600; i++) step(1'b1, {5'(i), 5'(i)});
    check("R7", bimodal_sel, 1'b1);
    for (int i = 0; i < 1024; i++) step(1'b1, 10'(1023 - i));
    for (int i = 0; i < 1100; i++) step(1'b1, {5'(i), ~5'(i)});
    check("R7", bimodal_sel, 1'b0);
    for (int i = 0; i < 1024; i++) step(1'b1, 10'(i * 5));
    for (int i = 0; i < 513; i++) step(1'b1, {5'(i * 3), 5'(i * 3)});
    for (int i = 0; i < 2000; i++) step(1'b1, 10'((i * 29) % 1024));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule